// File: doc/BRIEF.md
# Bit-Serial Adder with Carry State Machine

This block adds two N-bit unsigned operands one bit position per clock cycle. While reset is held, both operands are captured into right-shifting registers, the sum register is cleared and a step counter is preset. After reset is released, each cycle moves the lowest remaining operand bits into a carry-keeping state machine. The resulting sum bit enters the top of the sum register. When the counter reaches zero, shifting stops, `busy` falls and `sum` holds the result until the next reset.

A parameter selects one of two carry machines. The first is a two-state machine whose sum bit is formed combinationally from the current operand bits and the stored carry. The second is a four-state machine that registers the sum bit together with the carry. That bit therefore reaches the sum register one cycle late, and the counter adds one extra step so that the register stays aligned. A new addition is started only by reset.

Top module: `bsa_serial_adder`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `sum` reads 0 and `busy` reads 1. The operands present on the last reset cycle are the ones that get added.
- R2: With `MOORE=0`, every running cycle shifts `sum` right by one place and inserts a XOR b XOR carry at bit N-1. After k cycles (k<N), `sum` therefore equals (A+B mod 2^k) shifted left by N-k.
- R3: With `MOORE=0`, `busy` stays high for exactly N cycles after reset is released. At that point `sum` equals (A+B) mod 2^N.
- R4: With `MOORE=1`, the first running cycle inserts a 0, and every later bit lags by one cycle. `busy` stays high for exactly N+1 cycles. After k cycles, `sum` equals (A+B mod 2^(k-1)) shifted left by N-k+1, and in the end it equals (A+B) mod 2^N.
- R5: Once `busy` is low, `busy` and `sum` do not change until the next reset, whatever happens on the operand inputs.
- R6: Changing `opnd_a` or `opnd_b` while `busy` is high, with reset low, has no effect on any later `sum` value.
- R7: The stored carry goes from 0 to 1 only when both operand bits are 1. It goes from 1 to 0 only when both are 0. The carry out of bit N-1 is discarded, so 0xFF+0x01 gives 0x00.
- R8: Asserting reset in the middle of an addition abandons it. Loading takes priority over shifting, and the next run adds the new operands from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset; loads the operands, presets the counter and clears the carry and the sum |
| opnd_a | input | N | First operand, sampled while `rst` is high |
| opnd_b | input | N | Second operand, sampled while `rst` is high |
| busy | output | 1 | High while shift steps remain |
| sum | output | N | Sum shift register; holds the result after `busy` falls |

## Verification
A wrong carry state shows up in `sum` on the very next running cycle, because every partial value of `sum` is fixed by R2 or R4. The bench compares `sum` and `busy` with a reference model on every clock, for both carry machines at once. A counter that is off by one shows up as `busy` falling one cycle early or late, and also as a result that is shifted by one place. Operand inputs are scrambled during runs and after completion, so a register that reloads when it should not corrupts the compared value within one cycle.

// File: rtl/bsa_pkg.sv
`timescale 1ns/1ps
package bsa_pkg;

   // Two-state carry machine: the state is the carry itself
   typedef enum logic {
      CY_G = 1'b0,
      CY_H = 1'b1
   } mealy_st_t;

   // Four-state carry machine: {carry, registered sum bit}
   typedef enum logic [1:0] {
      ST_G0 = 2'b00,
      ST_G1 = 2'b01,
      ST_H0 = 2'b10,
      ST_H1 = 2'b11
   } moore_st_t;

   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (z & (x | y));
   endfunction

   function automatic logic par3(input logic x, input logic y, input logic z);
      return x ^ y ^ z;
   endfunction

endpackage

// File: rtl/bsa_shreg.sv
`timescale 1ns/1ps
module bsa_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] par_in,
   input  logic         ser_in,
   output logic [W-1:0] q
);

   generate
      if (W < 2) begin : g_bad_w
         $error("bsa_shreg: W must be at least 2");
      end
   endgenerate

   // load wins over shift; shifting moves toward bit 0
   always_ff @(posedge clk) begin
      if (load)
         q <= par_in;
      else if (shift)
         q <= {ser_in, q[W-1:1]};
   end

endmodule

// File: rtl/bsa_downcnt.sv
`timescale 1ns/1ps
module bsa_downcnt #(
   parameter int INIT = 8
) (
   input  logic clk,
   input  logic load,
   output logic nonzero
);

   localparam int CW = $clog2(INIT + 1);
   localparam logic [CW-1:0] START = CW'(INIT);

   logic [CW-1:0] cnt_q;

   generate
      if (INIT < 1) begin : g_bad_init
         $error("bsa_downcnt: INIT must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (load)
         cnt_q <= START;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign nonzero = (cnt_q != '0);

endmodule

// File: rtl/bsa_carry_fsm.sv
`timescale 1ns/1ps
module bsa_carry_fsm
   import bsa_pkg::*;
#(
   parameter bit MOORE = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic a,
   input  logic b,
   output logic s,
   output logic carry
);

   generate
      if (MOORE) begin : g_moore
         moore_st_t st_q;
         logic      nxt_c, nxt_s;

         always_comb begin
            nxt_c = maj3(a, b, st_q[1]);
            nxt_s = par3(a, b, st_q[1]);
         end

         always_ff @(posedge clk) begin
            if (rst)
               st_q <= ST_G0;
            else if (en)
               st_q <= moore_st_t'({nxt_c, nxt_s});
         end

         assign s     = st_q[0];
         assign carry = st_q[1];
      end else begin : g_mealy
         mealy_st_t st_q;

         always_ff @(posedge clk) begin
            if (rst)
               st_q <= CY_G;
            else if (en) begin
               case (st_q)
                  CY_G: if (a & b)   st_q <= CY_H;
                  CY_H: if (!a & !b) st_q <= CY_G;
                  default:           st_q <= CY_G;
               endcase
            end
         end

         assign carry = (st_q == CY_H);
         assign s     = par3(a, b, carry);
      end
   endgenerate

endmodule

// File: rtl/bsa_serial_adder.sv
`timescale 1ns/1ps
module bsa_serial_adder #(
   parameter int N     = 8,
   parameter bit MOORE = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] opnd_a,
   input  logic [N-1:0] opnd_b,
   output logic         busy,
   output logic [N-1:0] sum
);

   localparam int LAT   = MOORE ? 1 : 0;
   localparam int STEPS = N + LAT;

   generate
      if (N < 2) begin : g_bad_n
         $error("bsa_serial_adder: N must be at least 2");
      end
   endgenerate

   logic [N-1:0] a_q, b_q;
   logic         shift_en;
   logic         a_lsb, b_lsb;
   logic         fsm_s, carry_q;

   bsa_shreg #(.W(N)) u_opa (
      .clk(clk), .load(rst), .shift(shift_en),
      .par_in(opnd_a), .ser_in(1'b0), .q(a_q)
   );

   bsa_shreg #(.W(N)) u_opb (
      .clk(clk), .load(rst), .shift(shift_en),
      .par_in(opnd_b), .ser_in(1'b0), .q(b_q)
   );

   bsa_downcnt #(.INIT(STEPS)) u_cnt (
      .clk(clk), .load(rst), .nonzero(shift_en)
   );

   assign a_lsb = a_q[0];
   assign b_lsb = b_q[0];

   bsa_carry_fsm #(.MOORE(MOORE)) u_fsm (
      .clk(clk), .rst(rst), .en(shift_en),
      .a(a_lsb), .b(b_lsb), .s(fsm_s), .carry(carry_q)
   );

   bsa_shreg #(.W(N)) u_sum (
      .clk(clk), .load(rst), .shift(shift_en),
      .par_in('0), .ser_in(fsm_s), .q(sum)
   );

   assign busy = shift_en;

endmodule

// File: rtl/bsa_serial_adder_chk.sv
`timescale 1ns/1ps
module bsa_serial_adder_chk #(
   parameter int N     = 8,
   parameter bit MOORE = 1'b0
) (
   input logic         clk,
   input logic         rst,
   input logic         busy,
   input logic [N-1:0] sum,
   input logic         en,
   input logic         a_bit,
   input logic         b_bit,
   input logic         carry
);

   localparam int STEPS = N + (MOORE ? 1 : 0);
   localparam int CW    = $clog2(STEPS + 1);

   logic [CW-1:0] since_rst;

   always_ff @(posedge clk) begin
      if (rst)
         since_rst <= '0;
      else if (since_rst != CW'(STEPS))
         since_rst <= since_rst + 1'b1;
   end

   AST_RESET_BUSY: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (busy && sum == '0)); // R1

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
      $past(rst) == 1'b0 |-> (busy == (since_rst != CW'(STEPS)))); // R3

   AST_SUM_SHIFT: assert property (@(posedge clk) disable iff (rst)
      busy |=> (sum[N-2:0] == $past(sum[N-1:1]))); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !busy |=> (!busy && $stable(sum))); // R5

   AST_CARRY_SET: assert property (@(posedge clk) disable iff (rst)
      (en && !carry && !(a_bit && b_bit)) |=> !carry); // R7

   AST_CARRY_CLR: assert property (@(posedge clk) disable iff (rst)
      (en && carry && (a_bit || b_bit)) |=> carry); // R7

   AST_CARRY_IDLE: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(carry)); // R5

endmodule

bind bsa_serial_adder bsa_serial_adder_chk #(.N(N), .MOORE(MOORE)) u_chk (
   .clk(clk), .rst(rst), .busy(busy), .sum(sum), .en(shift_en),
   .a_bit(a_lsb), .b_bit(b_lsb), .carry(carry_q)
);

// File: tb/bsa_serial_adder_test.sv
`timescale 1ns/1ps
module bsa_serial_adder_test;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] opnd_a = '0;
   logic [N-1:0] opnd_b = '0;
   logic         busy_me, busy_mo;
   logic [N-1:0] sum_me, sum_mo;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   bsa_serial_adder #(.N(N), .MOORE(1'b0)) uut (
      .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .busy(busy_me), .sum(sum_me)
   );

   bsa_serial_adder #(.N(N), .MOORE(1'b1)) uut_moore (
      .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .busy(busy_mo), .sum(sum_mo)
   );

   // reference: partial result after k running cycles
   function automatic logic [N-1:0] ref_sum(input longint s, input int k, input bit moore);
      int got;
      got = moore ? k - 1 : k;
      if (got <= 0) return '0;
      if (got >= N) return N'(s % (64'd1 << N));
      return N'((s % (64'd1 << got)) << (N - got));
   endfunction

   task automatic check_one(input bit moore, input int k, input longint s, input string tag);
      int          steps;
      logic        eb, gb;
      logic [N-1:0] es, gs;
      string       rq;
      steps = N + (moore ? 1 : 0);
      eb = (k < steps);
      es = ref_sum(s, k, moore);
      gb = moore ? busy_mo : busy_me;
      gs = moore ? sum_mo : sum_me;
      if (k == 0)          rq = "R1";
      else if (k > steps)  rq = "R5";
      else if (tag != "")  rq = tag;
      else if (k == steps) rq = moore ? "R4" : "R3";
      else                 rq = moore ? "R4" : "R2";
      n_chk++;
      if (gb !== eb || gs !== es) begin
         n_fail++;
         $display("FAIL %s moore=%0d k=%0d: busy=%b sum=%h, expected busy=%b sum=%h",
                  rq, moore, k, gb, gs, eb, es);
      end
   endtask

   // load at reset, run lim cycles checking both variants each cycle
   task automatic run_case(input logic [N-1:0] a, input logic [N-1:0] b,
                           input string tag, input int lim, input bit scramble);
      longint s;
      s = longint'(a) + longint'(b);
      @(negedge clk);
      rst = 1'b1; opnd_a = a; opnd_b = b;
      @(negedge clk);
      rst = 1'b0;
      check_one(1'b0, 0, s, tag);
      check_one(1'b1, 0, s, tag);
      for (int k = 1; k <= lim; k++) begin
         if (scramble) begin
            opnd_a = N'($urandom);
            opnd_b = N'($urandom);
         end
         @(negedge clk);
         check_one(1'b0, k, s, tag);
         check_one(1'b1, k, s, tag);
      end
   endtask

   initial begin
      rst = 1'b1;
      repeat (2) @(negedge clk);
      run_case(8'h00, 8'h00, "",   N + 4, 1'b0);
      run_case(8'h3C, 8'h5A, "",   N + 4, 1'b0);
      run_case(8'hAA, 8'h55, "",   N + 4, 1'b0);
      run_case(8'hFF, 8'h01, "R7", N + 4, 1'b0);
      run_case(8'h80, 8'h80, "R7", N + 4, 1'b0);
      run_case(8'hFF, 8'hFF, "R7", N + 4, 1'b0);
      run_case(8'h12, 8'h34, "R6", N + 6, 1'b1);
      run_case(8'h77, 8'h99, "R8", 3,     1'b0);
      run_case(8'h0F, 8'hF1, "R8", N + 4, 1'b0);
      run_case(8'hC3, 8'h6E, "R6", N + 6, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule